// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Acknowledge Gating

This block keeps a small last-in, first-out store of program-counter values for a processor core, and decides in which cycle a pending interrupt is taken. Call instructions push the supplied program counter, return instructions pop it back out, and an accepted interrupt pushes the same program-counter input on the core's behalf. Only the program counter is saved; the accumulator, status and any other state are left to software.

An interrupt is accepted only when these conditions all hold:
- at least one source is both pending and individually enabled;
- the master enable is high;
- the stack has a free slot;
- no call or return strobe is present in that cycle;
- the previous cycle was not itself an acknowledge.

On acceptance the block pulses an acknowledge with the index of the winning source, and in the same cycle a command telling the core to clear its master enable. Software has to set the master enable again if it wants nesting.

While the core is halted nothing is accepted unless a wake event arrives. A wake that meets every acceptance condition vectors as a normal acknowledge. Any other wake produces a resume pulse, telling the core to continue at the instruction after the halt. The call and return strobes are single-cycle commands with no back-pressure: a push into a full stack is dropped and flagged, and a pop from an empty stack is flagged. All outputs are registered. Reset clears the stack and forces the returned program counter to zero.

Top module: `ret_stack_irq`

## Requirements
- R1: After reset, `stk_empty`=1, `stk_full`=0, `pop_pc`=0, and `irq_ack`, `gie_clr`, `wake_resume`, `stk_ovf`, `stk_unf` are all 0. Full and empty are never both high.
- R2: Pops return the pushed values in reverse order. `pop_pc` takes the new value in the cycle after the `ret_pop` strobe and holds it until the next pop.
- R3: After DEPTH (default 4) pushes without pops, `stk_full`=1. A lone `call_push` while full stores nothing and pulses `stk_ovf` for exactly one cycle.
- R4: A lone `ret_pop` while empty leaves the stack empty. It returns the content of slot 0, which is the value most recently popped out of the bottom, and pulses `stk_unf` for one cycle.
- R5: `call_push` and `ret_pop` in the same cycle return the current top and replace it with `push_pc`, so the depth is unchanged and no overflow is flagged even when full. If the stack was empty, this pulses `stk_unf`, returns slot 0 and leaves one entry.
- R6: A cycle that meets every acceptance condition gives `irq_ack`=1 and `gie_clr`=1 in the next cycle, and `push_pc` is stored on the stack.
- R7: Bit i of `irq_pend` and `irq_en` belongs to source i. The `irq_vec` value is the lowest i with both bits set.
- R8: No acknowledge is given while the stack is full. Once a pop frees a slot, the held request is acknowledged in the first cycle without a strobe.
- R9: A `call_push` or `ret_pop` strobe in a cycle defers acceptance, and the call's value goes on the stack beneath the interrupt's.
- R10: While `halted`=1, nothing is acknowledged without `wake`. When `wake` arrives and the acceptance conditions hold, the block vectors (`irq_ack`=1, `wake_resume`=0). Otherwise, because the source is disabled, the stack is full or the master enable is low, it pulses `wake_resume` and pushes nothing.
- R11: The cycle right after an acknowledge never acknowledges, even if the master enable is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_push | input | 1 | Call strobe: push `push_pc` |
| ret_pop | input | 1 | Return strobe: pop into `pop_pc` |
| push_pc | input | PC_W | Program counter to save (call or interrupt) |
| pop_pc | output | PC_W | Most recently popped program counter |
| irq_pend | input | NSRC | Pending request per source |
| irq_en | input | NSRC | Enable per source |
| gie | input | 1 | Master interrupt enable |
| halted | input | 1 | Core is in the halt state |
| wake | input | 1 | Wake event while halted |
| irq_ack | output | 1 | Interrupt accepted (one-cycle pulse) |
| irq_vec | output | VW | Index of the accepted source |
| gie_clr | output | 1 | Command to clear the master enable |
| wake_resume | output | 1 | Resume after the halt without vectoring |
| stk_full | output | 1 | All DEPTH slots occupied |
| stk_empty | output | 1 | No slot occupied |
| stk_ovf | output | 1 | Push into a full stack was dropped |
| stk_unf | output | 1 | Pop from an empty stack |

## Verification
The collision that matters most is a call or return strobe landing in the same cycle as an otherwise acceptable interrupt. The bench raises a pending, enabled source with the master enable high together with a call strobe. It then judges by the acknowledge staying low for that cycle and rising one cycle later, and by the popped order showing the interrupt's address above the call's. A second overlap is a pop and a push in one cycle on a full or empty stack. It is judged by the unchanged depth, the absence of an overflow pulse and the value returned.

// File: rtl/rsi_pkg.sv
package rsi_pkg;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rsi_stack.sv
module rsi_stack
  import rsi_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  stk_op_e      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = idx_w(DEPTH);

  logic [SPW-1:0]            sp;
  logic [SPW-1:0]            sp_m1;
  logic [IW-1:0]             top_idx;
  logic [DEPTH-1:0][W-1:0]   slots;
  logic                      wr_en;
  logic [IW-1:0]             wr_idx;

  assign full    = (sp == SPW'(DEPTH));
  assign empty   = (sp == '0);
  assign sp_m1   = sp - 1'b1;
  assign top_idx = sp_m1[IW-1:0];

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = '0;
    unique case (op)
      STK_PUSH: begin
        wr_en  = !full;
        wr_idx = sp[IW-1:0];
      end
      STK_SWAP: begin
        wr_en  = 1'b1;
        wr_idx = empty ? '0 : top_idx;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && (wr_idx == IW'(i)))
        q <= din;
    end
    assign slots[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp   <= '0;
      dout <= '0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      unique case (op)
        STK_PUSH: begin
          if (full) ovf <= 1'b1;
          else      sp  <= sp + 1'b1;
        end
        STK_POP: begin
          if (empty) begin
            dout <= slots[0];
            unf  <= 1'b1;
          end else begin
            dout <= slots[top_idx];
            sp   <= sp_m1;
          end
        end
        STK_SWAP: begin
          if (empty) begin
            dout <= slots[0];
            unf  <= 1'b1;
            sp   <= SPW'(1);
          end else begin
            dout <= slots[top_idx];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rsi_prio.sv
module rsi_prio
  import rsi_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]        req,
  output logic                any,
  output logic [idx_w(N)-1:0] idx
);
  localparam int VW = idx_w(N);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = VW'(i);
    end
  end

endmodule

// File: rtl/ret_stack_irq.sv
module ret_stack_irq
  import rsi_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int DEPTH = 4,
  parameter int NSRC  = 4,
  localparam int VW   = idx_w(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_push,
  input  logic            ret_pop,
  input  logic [PC_W-1:0] push_pc,
  output logic [PC_W-1:0] pop_pc,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic            gie,
  input  logic            halted,
  input  logic            wake,
  output logic            irq_ack,
  output logic [VW-1:0]   irq_vec,
  output logic            gie_clr,
  output logic            wake_resume,
  output logic            stk_full,
  output logic            stk_empty,
  output logic            stk_ovf,
  output logic            stk_unf
);
  logic [NSRC-1:0] live_req;
  logic            any_req;
  logic [VW-1:0]   win_idx;
  logic            take;
  logic            push_any;
  stk_op_e         op;
  logic            ack_q;
  logic [VW-1:0]   vec_q;
  logic            resume_q;

  assign live_req = irq_pend & irq_en;

  rsi_prio #(.N(NSRC)) u_prio (
    .req (live_req),
    .any (any_req),
    .idx (win_idx)
  );

  // Acceptance: enabled request, master enable, room, no strobe, not just acked, awake
  assign take = gie && any_req && !stk_full && !call_push && !ret_pop
                && !ack_q && (!halted || wake);

  assign push_any = call_push || take;

  always_comb begin
    unique case ({push_any, ret_pop})
      2'b10:   op = STK_PUSH;
      2'b01:   op = STK_POP;
      2'b11:   op = STK_SWAP;
      default: op = STK_IDLE;
    endcase
  end

  rsi_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .din   (push_pc),
    .dout  (pop_pc),
    .full  (stk_full),
    .empty (stk_empty),
    .ovf   (stk_ovf),
    .unf   (stk_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      vec_q    <= '0;
      resume_q <= 1'b0;
    end else begin
      ack_q    <= take;
      resume_q <= halted && wake && !take;
      if (take) vec_q <= win_idx;
    end
  end

  assign irq_ack     = ack_q;
  assign irq_vec     = vec_q;
  assign gie_clr     = ack_q;
  assign wake_resume = resume_q;

endmodule

// File: rtl/ret_stack_irq_chk.sv
module ret_stack_irq_chk #(
  parameter int PC_W = 11,
  parameter int NSRC = 4,
  parameter int VW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            call_push,
  input logic            ret_pop,
  input logic [NSRC-1:0] irq_pend,
  input logic [NSRC-1:0] irq_en,
  input logic            gie,
  input logic            halted,
  input logic            wake,
  input logic            irq_ack,
  input logic [VW-1:0]   irq_vec,
  input logic            wake_resume,
  input logic            stk_full,
  input logic            stk_empty,
  input logic            stk_ovf,
  input logic            stk_unf
);

  assert_full_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_full && stk_empty));

  assert_ovf_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> $past(stk_full));

  assert_unf_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf |-> $past(stk_empty));

  assert_ack_needs_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(gie));

  assert_ack_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (($past(irq_pend & irq_en) &
                  ((NSRC'(1) << irq_vec) - NSRC'(1))) == '0));

  assert_no_ack_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !$past(stk_full));

  assert_ack_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(!call_push && !ret_pop));

  assert_resume_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_resume |-> (!irq_ack && $past(halted && wake)));

  assert_halt_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(!halted || wake));

  assert_ack_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

endmodule

bind ret_stack_irq ret_stack_irq_chk #(.PC_W(PC_W), .NSRC(NSRC), .VW(VW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .call_push   (call_push),
  .ret_pop     (ret_pop),
  .irq_pend    (irq_pend),
  .irq_en      (irq_en),
  .gie         (gie),
  .halted      (halted),
  .wake        (wake),
  .irq_ack     (irq_ack),
  .irq_vec     (irq_vec),
  .wake_resume (wake_resume),
  .stk_full    (stk_full),
  .stk_empty   (stk_empty),
  .stk_ovf     (stk_ovf),
  .stk_unf     (stk_unf)
);

// File: tb/ret_stack_irq_test.sv
module ret_stack_irq_test;
  localparam int PC_W  = 11;
  localparam int DEPTH = 4;
  localparam int NSRC  = 4;
  localparam int VW    = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            call_push = 1'b0;
  logic            ret_pop = 1'b0;
  logic [PC_W-1:0] push_pc = '0;
  logic [PC_W-1:0] pop_pc;
  logic [NSRC-1:0] irq_pend = '0;
  logic [NSRC-1:0] irq_en = '0;
  logic            gie = 1'b0;
  logic            halted = 1'b0;
  logic            wake = 1'b0;
  logic            irq_ack;
  logic [VW-1:0]   irq_vec;
  logic            gie_clr;
  logic            wake_resume;
  logic            stk_full, stk_empty, stk_ovf, stk_unf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ret_stack_irq #(.PC_W(PC_W), .DEPTH(DEPTH), .NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .call_push(call_push), .ret_pop(ret_pop),
    .push_pc(push_pc), .pop_pc(pop_pc), .irq_pend(irq_pend), .irq_en(irq_en),
    .gie(gie), .halted(halted), .wake(wake), .irq_ack(irq_ack),
    .irq_vec(irq_vec), .gie_clr(gie_clr), .wake_resume(wake_resume),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_ovf(stk_ovf),
    .stk_unf(stk_unf)
  );

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic push_one(input int v);
    call_push = 1'b1;
    push_pc = PC_W'(v);
    step();
    call_push = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input int expv);
    ret_pop = 1'b1;
    step();
    ret_pop = 1'b0;
    chk(tag, int'(pop_pc), expv);
  endtask

  task automatic drain;
    while (!stk_empty) begin
      ret_pop = 1'b1;
      step();
      ret_pop = 1'b0;
    end
  endtask

  function automatic int lowest(input int m);
    for (int i = 0; i < NSRC; i++) if (m[i]) return i;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 empty", int'(stk_empty), 1);
    chk("R1 full", int'(stk_full), 0);
    chk("R1 pop_pc", int'(pop_pc), 0);
    chk("R1 ack", int'(irq_ack), 0);
    chk("R1 gie_clr", int'(gie_clr), 0);
    chk("R1 resume", int'(wake_resume), 0);
    chk("R1 ovf", int'(stk_ovf), 0);
    chk("R1 unf", int'(stk_unf), 0);

    // R3 fill and overflow
    for (int i = 1; i <= DEPTH; i++) push_one(100 + i);
    chk("R3 full", int'(stk_full), 1);
    chk("R3 no ovf yet", int'(stk_ovf), 0);
    push_one(999);
    chk("R3 ovf pulse", int'(stk_ovf), 1);
    step();
    chk("R3 ovf one cycle", int'(stk_ovf), 0);

    // R5 swap while full
    call_push = 1'b1; ret_pop = 1'b1; push_pc = PC_W'(200);
    step();
    call_push = 1'b0; ret_pop = 1'b0;
    chk("R5 swap returns top", int'(pop_pc), 100 + DEPTH);
    chk("R5 still full", int'(stk_full), 1);
    chk("R5 no ovf", int'(stk_ovf), 0);

    // R2 LIFO order (R3: dropped 999 absent)
    pop_chk("R2 pop top", 200);
    for (int i = DEPTH - 1; i >= 1; i--) pop_chk("R2 pop order", 100 + i);
    chk("R2 empty", int'(stk_empty), 1);
    step();
    chk("R2 pop_pc held", int'(pop_pc), 101);

    // R4 underflow
    pop_chk("R4 underflow value", 101);
    chk("R4 unf pulse", int'(stk_unf), 1);
    chk("R4 still empty", int'(stk_empty), 1);
    step();
    chk("R4 unf one cycle", int'(stk_unf), 0);

    // R5 swap on empty
    call_push = 1'b1; ret_pop = 1'b1; push_pc = PC_W'(300);
    step();
    call_push = 1'b0; ret_pop = 1'b0;
    chk("R5 empty swap value", int'(pop_pc), 101);
    chk("R5 empty swap unf", int'(stk_unf), 1);
    chk("R5 one entry", int'(stk_empty), 0);
    pop_chk("R5 stored", 300);
    chk("R5 empty again", int'(stk_empty), 1);

    // R6/R7 sweep of all pending/enable patterns
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        irq_pend = NSRC'(p); irq_en = NSRC'(e); gie = 1'b1;
        push_pc = PC_W'(p * 16 + e);
        step();
        gie = 1'b0; irq_pend = '0;
        chk("R6 ack", int'(irq_ack), int'((p & e) != 0));
        chk("R6 gie_clr", int'(gie_clr), int'((p & e) != 0));
        if ((p & e) != 0) begin
          chk("R7 vector", int'(irq_vec), lowest(p & e));
          pop_chk("R6 saved pc", p * 16 + e);
          chk("R11 no re-ack", int'(irq_ack), 0);
        end else begin
          chk("R6 nothing stored", int'(stk_empty), 1);
        end
      end
    end

    // R11 spacing with gie held high
    irq_pend = 4'b0100; irq_en = 4'b1111; gie = 1'b1; push_pc = PC_W'(5);
    step();
    chk("R11 first ack", int'(irq_ack), 1);
    step();
    chk("R11 gap", int'(irq_ack), 0);
    step();
    chk("R11 second ack", int'(irq_ack), 1);
    chk("R7 vec 2", int'(irq_vec), 2);
    gie = 1'b0; irq_pend = '0;
    pop_chk("R11 pop", 5);
    pop_chk("R11 pop", 5);

    // R8 full gating
    for (int i = 1; i <= DEPTH; i++) push_one(i);
    irq_pend = 4'b0010; irq_en = 4'b0010; gie = 1'b1; push_pc = PC_W'(9);
    step();
    chk("R8 held while full", int'(irq_ack), 0);
    ret_pop = 1'b1;
    step();
    ret_pop = 1'b0;
    chk("R8 pop value", int'(pop_pc), DEPTH);
    chk("R8 no ack in pop cycle", int'(irq_ack), 0);
    step();
    chk("R8 ack after pop", int'(irq_ack), 1);
    chk("R8 vec", int'(irq_vec), 1);
    chk("R8 full again", int'(stk_full), 1);
    gie = 1'b0; irq_pend = '0;
    pop_chk("R8 drain", 9);
    for (int i = DEPTH - 1; i >= 1; i--) pop_chk("R8 drain", i);

    // R9 call in same cycle as acceptable request
    irq_pend = 4'b0001; irq_en = 4'b0001; gie = 1'b1;
    call_push = 1'b1; push_pc = PC_W'(7);
    step();
    call_push = 1'b0; push_pc = PC_W'(8);
    chk("R9 deferred", int'(irq_ack), 0);
    chk("R9 call stored", int'(stk_empty), 0);
    step();
    chk("R9 ack next", int'(irq_ack), 1);
    gie = 1'b0; irq_pend = '0;
    pop_chk("R9 irq on top", 8);
    pop_chk("R9 call below", 7);

    // R10 halt gating and wake outcomes
    halted = 1'b1; gie = 1'b1; irq_pend = 4'b0001; irq_en = 4'b0001;
    push_pc = PC_W'(12);
    step();
    chk("R10 no ack halted", int'(irq_ack), 0);
    chk("R10 no resume", int'(wake_resume), 0);
    wake = 1'b1;
    step();
    wake = 1'b0;
    chk("R10 wake vectors", int'(irq_ack), 1);
    chk("R10 no resume on vector", int'(wake_resume), 0);
    halted = 1'b0; gie = 1'b0;
    pop_chk("R10 saved", 12);
    halted = 1'b1; irq_en = '0; gie = 1'b1; wake = 1'b1;
    step();
    wake = 1'b0;
    chk("R10 disabled resume", int'(wake_resume), 1);
    chk("R10 disabled no ack", int'(irq_ack), 0);
    chk("R10 disabled no push", int'(stk_empty), 1);
    step();
    chk("R10 resume one cycle", int'(wake_resume), 0);
    irq_en = 4'b0001; gie = 1'b0; wake = 1'b1;
    step();
    wake = 1'b0;
    chk("R10 gie low resume", int'(wake_resume), 1);
    halted = 1'b0;

    // R10 depth sweep: wake vectors unless full
    for (int d = 0; d <= DEPTH; d++) begin
      gie = 1'b0; irq_pend = '0;
      for (int i = 0; i < d; i++) push_one(50 + i);
      halted = 1'b1; gie = 1'b1; irq_pend = 4'b0001; wake = 1'b1;
      push_pc = PC_W'(77);
      step();
      wake = 1'b0; gie = 1'b0; irq_pend = '0; halted = 1'b0;
      chk("R10 depth ack", int'(irq_ack), int'(d < DEPTH));
      chk("R10 depth resume", int'(wake_resume), int'(d == DEPTH));
      step();
      drain();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule